// File: doc/BRIEF.md
# Lock-After-First-Write Watchdog Timer

This block is a watchdog timer with a single 32-bit control word. The first write after reset sets up the timer and then locks that setup. The setup holds a 12-bit reload count, a prescaler select, a run enable and a two-bit expiry action. Every later write, whatever its data, only reloads the countdown. Software keeps the system alive by writing to the register at any value before the count runs out.

The counter steps on a clock enable that fires every second bus clock. The prescaler select can also put a divide-by-`PRESC_DIV` stage in front of the counter. When the count runs out, the block raises an interrupt line and/or a reset-request line, as the action field selects. Both lines stay high until reset. Reading the register returns the locked setup together with a configured flag.

Top module: `wdt_once`

## Requirements
- R1: After reset, `rd_data` reads 0 and both `irq` and `rst_req` are low.
- R2: The first write after reset stores `wr_data[15:0]`. Bits 11:0 are the reload count, bit 12 is the prescaler select, bit 13 is the run enable and bits 15:14 are the action. `rd_data` then returns these 16 bits with bit 16 set to 1 (configured) and bits 31:17 at 0.
- R3: Once configured, no write changes any bit of `rd_data`, whatever its data.
- R4: Once configured, any write reloads the counter from the stored reload count and clears the prescaler. A write in the same cycle as a count step wins over the step.
- R5: With the prescaler off, the counter steps down once every two clocks. For a reload of N≥1, expiry comes between 2N-1 and 2N clocks after the configuring or restarting write.
- R6: With the prescaler on, each count step needs `PRESC_DIV` half-rate enables. Expiry then comes between 2·PRESC_DIV·N-1 and 2·PRESC_DIV·N clocks after the write.
- R7: The action sets the outputs on expiry. Value 2 raises `irq` only, 3 raises `irq` and `rst_req`, 1 raises `rst_req` only, and 0 raises neither.
- R8: After expiry the outputs stay high until reset, even across restart writes. The counter stops at zero and does not wrap.
- R9: With the run enable at 0, the counter never steps and the block never expires.
- R10: A reload count of 0 with the run enable set expires on the first count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Locked setup (bits 15:0) and configured flag (bit 16) |
| irq | output | 1 | Sticky expiry interrupt |
| rst_req | output | 1 | Sticky expiry reset request |

## Verification
The bench writes all-ones after the setup write. A design that let a second write through would show the changed setup on readback. Restart writes keep arriving just inside the timeout. A design that let a count step win over the restart, or that left the prescaler running across a restart, would expire early. The bench also covers a zero reload, a disabled timer and all four action codes. A design that wrapped the counter, mapped the action bits wrongly or cleared the outputs on restart would show the wrong output level at the cycle the reference model predicts.

// File: rtl/wdt_once.sv
module wdt_once #(
  parameter int RLD_W     = 12,
  parameter int PRESC_DIV = 16384,
  parameter int BUS_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq,
  output logic             rst_req
);
  localparam int PRE_BIT = RLD_W;
  localparam int EN_BIT  = RLD_W + 1;
  localparam int CFG_W   = RLD_W + 4;
  localparam int PW      = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PDIV_LAST = PW'(PRESC_DIV - 1);

  logic [CFG_W-1:0] cfg_q;
  logic             locked_q, half_q, fired_q;
  logic [RLD_W-1:0] cnt_q;
  logic [PW-1:0]    pdiv_q;
  logic             unused_hi;

  wire [RLD_W-1:0] reload = cfg_q[RLD_W-1:0];
  wire [1:0]       act    = cfg_q[CFG_W-1 -: 2];
  wire             pre    = cfg_q[PRE_BIT];
  wire             step   = locked_q & cfg_q[EN_BIT] & half_q;
  wire             pwrap  = (pdiv_q == PDIV_LAST);
  wire             dec    = step & (~pre | pwrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
      half_q   <= 1'b0;
      fired_q  <= 1'b0;
      cnt_q    <= '0;
      pdiv_q   <= '0;
    end else begin
      half_q <= ~half_q;
      if (wr_en && !locked_q) begin
        cfg_q    <= wr_data[CFG_W-1:0];
        locked_q <= 1'b1;
        cnt_q    <= wr_data[RLD_W-1:0];
        pdiv_q   <= '0;
      end else if (wr_en) begin
        cnt_q  <= reload;
        pdiv_q <= '0;
      end else begin
        if (step && pre)
          pdiv_q <= pwrap ? '0 : pdiv_q + PW'(1);
        if (dec) begin
          if (cnt_q != '0) cnt_q <= cnt_q - RLD_W'(1);
          if (cnt_q < RLD_W'(2)) fired_q <= 1'b1;
        end
      end
    end
  end

  assign irq       = fired_q & act[1];
  assign rst_req   = fired_q & act[0];
  assign rd_data   = {{(BUS_W-CFG_W-1){1'b0}}, locked_q, cfg_q};
  assign unused_hi = ^wr_data[BUS_W-1:CFG_W];
endmodule

module wdt_once_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        irq,
  input logic        rst_req
);
  AST_SETUP_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n) rd_data[16] |=> $stable(rd_data)); // R3
  AST_IRQ_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) irq |=> irq); // R8
  AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req); // R8
  AST_IRQ_ACTION:    assert property (@(posedge clk) disable iff (!rst_n) irq |-> rd_data[15]); // R7
  AST_RSTREQ_ACTION: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> rd_data[14]); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[16] && !rd_data[13]) |-> (!irq && !rst_req)); // R9
  AST_UNSET_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !rd_data[16] |-> (rd_data == 32'd0 && !irq && !rst_req)); // R1
endmodule

bind wdt_once wdt_once_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
);

// File: tb/wdt_once_tb.sv
module wdt_once_tb_top;
  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wdt_once #(.RLD_W(12), .PRESC_DIV(P), .BUS_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  int m_half, m_cfg, m_rel, m_pre, m_en, m_act, m_cnt, m_pd, m_fired;
  bit m_valid = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_half = 0; m_cfg = 0; m_rel = 0; m_pre = 0; m_en = 0;
      m_act = 0; m_cnt = 0; m_pd = 0; m_fired = 0; m_valid = 1'b1;
    end else begin
      bit tick, do_dec;
      tick = (m_half == 1);
      m_half = 1 - m_half;
      if (wr_en && m_cfg == 0) begin
        m_cfg = 1;
        m_rel = wr_data & 4095;
        m_pre = (wr_data >> 12) & 1;
        m_en  = (wr_data >> 13) & 1;
        m_act = (wr_data >> 14) & 3;
        m_cnt = m_rel; m_pd = 0;
      end else if (wr_en) begin
        m_cnt = m_rel; m_pd = 0;
      end else if (m_cfg == 1 && m_en == 1 && tick) begin
        do_dec = 1'b1;
        if (m_pre == 1) begin
          m_pd++;
          if (m_pd == P) m_pd = 0;
          else do_dec = 1'b0;
        end
        if (do_dec) begin
          if (m_cnt <= 1) m_fired = 1;
          if (m_cnt > 0) m_cnt--;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_valid) begin
      logic [31:0] e_rd;
      e_rd = (m_cfg == 1) ? ((32'd1 << 16) | (m_act << 14) | (m_en << 13) | (m_pre << 12) | m_rel) : 32'd0;
      chk("R7 model irq", {31'd0, irq}, {31'd0, (m_fired == 1) && ((m_act & 2) != 0)});
      chk("R7 model rst_req", {31'd0, rst_req}, {31'd0, (m_fired == 1) && ((m_act & 1) != 0)});
      chk("R2 model readback", rd_data, e_rd);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input string req, input bit ei, input bit er);
    chk(req, {30'd0, irq, rst_req}, {30'd0, ei, er});
  endtask

  initial begin
    #1500000;
    fails++; total++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    tick(1);
    chk("R1 reset readback", rd_data, 32'd0);
    outs("R1 reset outputs", 1'b0, 1'b0);

    wr(32'h0000_A005);
    chk("R2 setup readback", rd_data, 32'h0001_A005);
    tick(8);  outs("R5 not yet expired", 1'b0, 1'b0);
    tick(2);  outs("R5 R7 expired irq only", 1'b1, 1'b0);
    wr(32'hFFFF_FFFF);
    chk("R3 second write ignored", rd_data, 32'h0001_A005);
    tick(20); outs("R8 sticky after restart", 1'b1, 1'b0);

    do_reset();
    wr(32'h0000_E004);
    for (int i = 0; i < 10; i++) begin
      tick(3); wr(32'h0000_0000);
    end
    outs("R4 restarts hold off expiry", 1'b0, 1'b0);
    chk("R3 restart data ignored", rd_data, 32'h0001_E004);
    tick(6);  outs("R4 reload after restart", 1'b0, 1'b0);
    tick(2);  outs("R7 action 3 both", 1'b1, 1'b1);

    do_reset();
    wr(32'h0000_7002);
    tick(2*P*2 - 2); outs("R6 prescaled not yet", 1'b0, 1'b0);
    tick(2);         outs("R6 R7 action 1 reset only", 1'b0, 1'b1);

    do_reset();
    wr(32'h0000_2003);
    tick(20); outs("R7 action 0 silent", 1'b0, 1'b0);

    do_reset();
    wr(32'h0000_C003);
    tick(30); outs("R9 disabled never expires", 1'b0, 1'b0);
    wr(32'h0000_FFFF);
    tick(30); outs("R9 disabled after restart", 1'b0, 1'b0);
    chk("R9 setup stays disabled", rd_data, 32'h0001_C003);

    do_reset();
    wr(32'h0000_A000);
    tick(2); outs("R10 zero reload expires at first step", 1'b1, 1'b0);
    tick(10); outs("R8 no wrap, still high", 1'b1, 1'b0);

    tick(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule